// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block runs the two low-power standby modes of a small 8-bit microcontroller core. The core raises a request for a light mode (SLEEP), which only stops the CPU clock, or a deep mode (STOP), which also turns the oscillator off. While the core is in standby, the controller watches a set of wake sources. The mode decides which sources count: the interval timer can end SLEEP but not STOP.

A wake from SLEEP gives the CPU clock back on the next reference clock edge. A wake from STOP first turns the oscillator on again. The controller then waits a settling time picked by a 3-bit selector, and only after that sets the clock-enable flag and the CPU clock enable. When the clocks come back, the controller gives the core a one-cycle decision. It either resumes inline at the instruction after the standby instruction, or takes the interrupt vector of the source that caused the wake.

The key pins and the external interrupt pins are asynchronous. Each passes through a two-flop synchronizer before it is qualified as a wake source.

Top module: `stby_wake_ctrl`

## Requirements
- R1: A cycle with `rst` high puts the block back in run mode at the next edge, from any mode. After that edge `osc_en`, `cpu_clk_en` and `clk_en_flag` are 1, `resume_pulse` and `vector_req` are 0, and `vector_id` is 0.
- R2: In run mode (`cpu_clk_en` = 1), `stop_req` takes priority over `sleep_req`. A stop request clears `osc_en`, `cpu_clk_en` and `clk_en_flag` at the next edge. A sleep request alone clears only `cpu_clk_en` and leaves `osc_en` at 1.
- R3: A key pin `k` wakes the core when its synchronized level is 0 and `key_sel[k]` = 1. Pins with `key_sel[k]` = 0 are ignored. Because of the synchronizer, a pin change takes effect at the third rising edge after it.
- R4: An external interrupt pin wakes the core only on a synchronized rising edge, and only while its enable is set (`int_en[0]` for `int1`, `int_en[1]` for `int2`). A steady high level is not a wake. An edge seen while the pin is disabled is not a wake.
- R5: `itmr_tick` wakes SLEEP only when `itmr_src_ok` and `itmr_ie` are both 1. It never wakes STOP.
- R6: A SLEEP wake seen before an edge sets `cpu_clk_en` at that edge. `osc_en` stays 1 throughout and there is no settling wait.
- R7: A STOP wake sets `osc_en` at the edge where it is seen and samples `settle_sel` = n at that edge. `cpu_clk_en` and `clk_en_flag` rise exactly 2^(n+SETTLE_BASE) cycles later.
- R8: In the edge where the clocks return, exactly one one-cycle pulse is given. The pulse is `vector_req` if `irq_master_en` = 1 at that edge, and `resume_pulse` otherwise.
- R9: `vector_id` is loaded at the wake edge with the code of the highest-priority active source: key = 0, `int1` = 1, `int2` = 2, timer = 3. A lower code wins.
- R10: Wake sources have no effect in run mode or during the STOP settling wait. No pulse and no change of mode results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| sleep_req | input | 1 | Core requests the light standby mode |
| stop_req | input | 1 | Core requests the deep standby mode |
| key_in | input | KEY_W | Asynchronous key-scan pins, active low |
| key_sel | input | KEY_W | Per-pin key wake enable |
| int1 | input | 1 | Asynchronous external interrupt pin 1 |
| int2 | input | 1 | Asynchronous external interrupt pin 2 |
| int_en | input | 2 | Enables for int1 (bit 0) and int2 (bit 1) |
| itmr_tick | input | 1 | Interval timer interrupt event |
| itmr_src_ok | input | 1 | Timer is clocked from the prescaler tap allowed to wake SLEEP |
| itmr_ie | input | 1 | Interval timer interrupt enable |
| irq_master_en | input | 1 | Global interrupt enable; picks vector over inline resume |
| settle_sel | input | SEL_W | Oscillator settling selector |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| clk_en_flag | output | 1 | Peripheral/CPU clock-enable flag, set after settling |
| resume_pulse | output | 1 | One-cycle pulse: resume at the next instruction |
| vector_req | output | 1 | One-cycle pulse: enter the service routine |
| vector_id | output | 2 | Wake source code for the vector |

## Verification
The bench builds the block with KEY_W = 8, SEL_W = 3 and SETTLE_BASE = 2. With these values the longest settling wait is 512 cycles, so both a short and the longest selector run to completion in one short run. The test also changes the selector during a wait, which shows that it is sampled at the wake edge. The narrower key bus still mixes selected and unselected pins. Simultaneous wakes (key with int2, int1 with int2, int2 with the timer) cover the priority order.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_STOP   = 2'd2,
    ST_SETTLE = 2'd3
  } stby_state_t;

  typedef enum logic [1:0] {
    SRC_KEY  = 2'd0,
    SRC_INT1 = 2'd1,
    SRC_INT2 = 2'd2,
    SRC_TMR  = 2'd3
  } wake_src_t;

  typedef struct packed {
    logic key;
    logic int1;
    logic int2;
    logic tmr;
  } wake_vec_t;

  // fixed priority: lower code wins
  function automatic wake_src_t pick_src(wake_vec_t w);
    if (w.key)       return SRC_KEY;
    else if (w.int1) return SRC_INT1;
    else if (w.int2) return SRC_INT2;
    else             return SRC_TMR;
  endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
  import stby_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key_s,
  input  logic [KEY_W-1:0] key_sel,
  input  logic [1:0]       ext_s,
  input  logic [1:0]       int_en,
  input  logic             itmr_tick,
  input  logic             itmr_src_ok,
  input  logic             itmr_ie,
  output wake_vec_t        wake
);
  logic [1:0] ext_prev;
  logic [1:0] ext_rise;

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= '0;
    else     ext_prev <= ext_s;
  end

  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign ext_rise[g] = ext_s[g] & ~ext_prev[g] & int_en[g];
  end

  always_comb begin
    wake.key  = |(~key_s & key_sel);
    wake.int1 = ext_rise[0];
    wake.int2 = ext_rise[1];
    wake.tmr  = itmr_tick & itmr_src_ok & itmr_ie;
  end
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int SEL_W = 3,
  parameter int BASE  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = (1 << SEL_W) + BASE;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;
  logic             running;

  always_comb span = (CNT_W'(1) << (int'(sel) + BASE)) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= span;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - CNT_W'(1);
    end
  end

  assign done = running && (cnt == '0);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int KEY_W       = 16,
  parameter int SEL_W       = 3,
  parameter int SETTLE_BASE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             stop_req,
  input  logic [KEY_W-1:0] key_in,
  input  logic [KEY_W-1:0] key_sel,
  input  logic             int1,
  input  logic             int2,
  input  logic [1:0]       int_en,
  input  logic             itmr_tick,
  input  logic             itmr_src_ok,
  input  logic             itmr_ie,
  input  logic             irq_master_en,
  input  logic [SEL_W-1:0] settle_sel,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             clk_en_flag,
  output logic             resume_pulse,
  output logic             vector_req,
  output logic [1:0]       vector_id
);
  stby_state_t state;
  logic [KEY_W-1:0] key_s;
  logic [1:0]       ext_s;
  wake_vec_t        wake;
  logic             wake_sleep, wake_stop, settle_load, settle_done;

  stby_sync #(.W(KEY_W), .RST_VAL({KEY_W{1'b1}})) i_key_sync (
    .clk(clk), .rst(rst), .d(key_in), .q(key_s));

  stby_sync #(.W(2), .RST_VAL(2'b00)) i_ext_sync (
    .clk(clk), .rst(rst), .d({int2, int1}), .q(ext_s));

  stby_wake_qual #(.KEY_W(KEY_W)) i_qual (
    .clk(clk), .rst(rst), .key_s(key_s), .key_sel(key_sel), .ext_s(ext_s),
    .int_en(int_en), .itmr_tick(itmr_tick), .itmr_src_ok(itmr_src_ok),
    .itmr_ie(itmr_ie), .wake(wake));

  assign wake_sleep  = wake.key | wake.int1 | wake.int2 | wake.tmr;
  assign wake_stop   = wake.key | wake.int1 | wake.int2;
  assign settle_load = (state == ST_STOP) && wake_stop;

  stby_settle_cnt #(.SEL_W(SEL_W), .BASE(SETTLE_BASE)) i_settle (
    .clk(clk), .rst(rst), .load(settle_load), .sel(settle_sel), .done(settle_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      osc_en       <= 1'b1;
      cpu_clk_en   <= 1'b1;
      clk_en_flag  <= 1'b1;
      resume_pulse <= 1'b0;
      vector_req   <= 1'b0;
      vector_id    <= 2'd0;
    end else begin
      resume_pulse <= 1'b0;
      vector_req   <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (stop_req) begin
            state       <= ST_STOP;
            osc_en      <= 1'b0;
            cpu_clk_en  <= 1'b0;
            clk_en_flag <= 1'b0;
          end else if (sleep_req) begin
            state      <= ST_SLEEP;
            cpu_clk_en <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (wake_sleep) begin
            state      <= ST_RUN;
            cpu_clk_en <= 1'b1;
            vector_id  <= pick_src(wake);
            vector_req   <= irq_master_en;
            resume_pulse <= ~irq_master_en;
          end
        end
        ST_STOP: begin
          if (wake_stop) begin
            state     <= ST_SETTLE;
            osc_en    <= 1'b1;
            vector_id <= pick_src(wake);
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            state        <= ST_RUN;
            cpu_clk_en   <= 1'b1;
            clk_en_flag  <= 1'b1;
            vector_req   <= irq_master_en;
            resume_pulse <= ~irq_master_en;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk #(
  parameter int SEL_W       = 3,
  parameter int SETTLE_BASE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic             stop_req,
  input logic [SEL_W-1:0] settle_sel,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             clk_en_flag,
  input logic             resume_pulse,
  input logic             vector_req,
  input logic [1:0]       vector_id
);
  logic             osc_q;
  logic [SEL_W-1:0] sel_prev, sel_q;
  logic             tracking;
  int               wait_cnt;

  // measures the cycles from oscillator restart to CPU clock return
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q    <= 1'b1;
      sel_prev <= '0;
      sel_q    <= '0;
      tracking <= 1'b0;
      wait_cnt <= 0;
    end else begin
      osc_q    <= osc_en;
      sel_prev <= settle_sel;
      if (!osc_q && osc_en) begin
        tracking <= 1'b1;
        wait_cnt <= 1;
        sel_q    <= sel_prev;
      end else if (tracking) begin
        if (cpu_clk_en) tracking <= 1'b0;
        else            wait_cnt <= wait_cnt + 1;
      end
    end
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (osc_en && cpu_clk_en && clk_en_flag && !resume_pulse && !vector_req && vector_id == 2'd0)); // R1
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && stop_req) |=> (!osc_en && !cpu_clk_en && !clk_en_flag)); // R2
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && !stop_req) |=> (osc_en && !cpu_clk_en)); // R2
  AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> osc_en); // R6
  AST_SETTLE_SPAN: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_clk_en) && tracking) |-> (wait_cnt == (1 << (int'(sel_q) + SETTLE_BASE)))); // R7
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(resume_pulse && vector_req)); // R8
  AST_OUTCOME_WITH_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (resume_pulse || vector_req) |-> (cpu_clk_en && clk_en_flag && $rose(cpu_clk_en))); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (resume_pulse || vector_req) |=> !(resume_pulse || vector_req)); // R8
endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk #(
  .SEL_W(SEL_W), .SETTLE_BASE(SETTLE_BASE)
) i_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .stop_req(stop_req),
  .settle_sel(settle_sel), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
  .clk_en_flag(clk_en_flag), .resume_pulse(resume_pulse),
  .vector_req(vector_req), .vector_id(vector_id)
);

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;
  localparam int SW = 3;
  localparam int SB = 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst, sleep_req, stop_req, int1, int2, itmr_tick, itmr_src_ok, itmr_ie, irq_master_en;
  logic [KW-1:0] key_in, key_sel;
  logic [1:0] int_en;
  logic [SW-1:0] settle_sel;
  logic osc_en, cpu_clk_en, clk_en_flag, resume_pulse, vector_req;
  logic [1:0] vector_id;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_wake_ctrl #(.KEY_W(KW), .SEL_W(SW), .SETTLE_BASE(SB)) i_stby_wake_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .stop_req(stop_req),
    .key_in(key_in), .key_sel(key_sel), .int1(int1), .int2(int2), .int_en(int_en),
    .itmr_tick(itmr_tick), .itmr_src_ok(itmr_src_ok), .itmr_ie(itmr_ie),
    .irq_master_en(irq_master_en), .settle_sel(settle_sel),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .clk_en_flag(clk_en_flag),
    .resume_pulse(resume_pulse), .vector_req(vector_req), .vector_id(vector_id));

  // behavioural reference: mode 0 run, 1 light, 2 deep, 3 waiting for oscillator
  int m_mode, m_left, m_vid;
  bit m_osc, m_cpu, m_flag, m_res, m_vreq;
  logic [KW-1:0] m_k1, m_k2;
  logic [1:0] m_e1, m_e2, m_ep;

  always @(posedge clk) begin
    bit kw, e1w, e2w, tw;
    int src;
    if (rst) begin
      m_mode = 0; m_left = 0; m_vid = 0;
      m_osc = 1; m_cpu = 1; m_flag = 1; m_res = 0; m_vreq = 0;
      m_k1 = '1; m_k2 = '1; m_e1 = '0; m_e2 = '0; m_ep = '0;
    end else begin
      kw  = ((~m_k2 & key_sel) != '0);
      e1w = m_e2[0] && !m_ep[0] && int_en[0];
      e2w = m_e2[1] && !m_ep[1] && int_en[1];
      tw  = itmr_tick && itmr_src_ok && itmr_ie;
      src = kw ? 0 : (e1w ? 1 : (e2w ? 2 : 3));
      m_res = 0; m_vreq = 0;
      case (m_mode)
        0: if (stop_req) begin m_mode = 2; m_osc = 0; m_cpu = 0; m_flag = 0; end
           else if (sleep_req) begin m_mode = 1; m_cpu = 0; end
        1: if (kw || e1w || e2w || tw) begin
             m_mode = 0; m_cpu = 1; m_vid = src;
             if (irq_master_en) m_vreq = 1; else m_res = 1;
           end
        2: if (kw || e1w || e2w) begin
             m_mode = 3; m_osc = 1; m_vid = src;
             m_left = 1 << (int'(settle_sel) + SB);
           end
        default: begin
          m_left = m_left - 1;
          if (m_left == 0) begin
            m_mode = 0; m_cpu = 1; m_flag = 1;
            if (irq_master_en) m_vreq = 1; else m_res = 1;
          end
        end
      endcase
      m_ep = m_e2; m_e2 = m_e1; m_e1 = {int2, int1};
      m_k2 = m_k1; m_k1 = key_in;
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if ({osc_en, cpu_clk_en, clk_en_flag, resume_pulse, vector_req} !== {m_osc, m_cpu, m_flag, m_res, m_vreq}
        || int'(vector_id) != m_vid) begin
      n_fail++;
      $display("FAIL model R1-related compare t=%0t actual=%b%b%b%b%b/%0d expected=%b%b%b%b%b/%0d",
               $time, osc_en, cpu_clk_en, clk_en_flag, resume_pulse, vector_req, vector_id,
               m_osc, m_cpu, m_flag, m_res, m_vreq, m_vid);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_req = 1; cyc(1); sleep_req = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1; sleep_req = 0; stop_req = 0; key_in = '1; key_sel = '0;
    int1 = 0; int2 = 0; int_en = 2'b00; itmr_tick = 0; itmr_src_ok = 0; itmr_ie = 0;
    irq_master_en = 0; settle_sel = '0;
    cyc(3); rst = 0;
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "clk_en_flag", clk_en_flag, 1);
    chk("R1", "resume_pulse", resume_pulse, 0);
    chk("R1", "vector_req", vector_req, 0);
    chk("R1", "vector_id", vector_id, 0);
    cyc(2);

    // light mode entry, then key wake
    go_sleep();
    chk("R2", "sleep cpu_clk_en", cpu_clk_en, 0);
    chk("R2", "sleep osc_en", osc_en, 1);
    key_sel = 8'h01; key_in = 8'hFD; cyc(5);
    chk("R3", "unselected key cpu_clk_en", cpu_clk_en, 0);
    key_in = 8'hFC; cyc(2);
    chk("R3", "sync latency cpu_clk_en", cpu_clk_en, 0);
    cyc(1);
    chk("R3", "key wake cpu_clk_en", cpu_clk_en, 1);
    chk("R6", "no settle osc_en", osc_en, 1);
    chk("R8", "resume_pulse", resume_pulse, 1);
    chk("R8", "vector_req", vector_req, 0);
    chk("R9", "key vector_id", vector_id, 0);
    cyc(1);
    chk("R8", "resume one cycle", resume_pulse, 0);
    cyc(4);
    chk("R10", "run key ignored cpu", cpu_clk_en, 1);
    chk("R10", "run key ignored pulse", resume_pulse, 0);
    key_in = '1; cyc(3);

    // timer gating
    go_sleep();
    itmr_tick = 1; itmr_src_ok = 1; itmr_ie = 0; cyc(3);
    chk("R5", "timer ie=0 cpu", cpu_clk_en, 0);
    itmr_src_ok = 0; itmr_ie = 1; cyc(3);
    chk("R5", "timer src=0 cpu", cpu_clk_en, 0);
    irq_master_en = 1; itmr_src_ok = 1; cyc(1);
    chk("R5", "timer wake cpu", cpu_clk_en, 1);
    chk("R8", "vector_req", vector_req, 1);
    chk("R8", "no resume", resume_pulse, 0);
    chk("R9", "timer vector_id", vector_id, 3);
    itmr_tick = 0; itmr_src_ok = 0; itmr_ie = 0; irq_master_en = 0; cyc(2);

    // external interrupt qualification
    go_sleep();
    int1 = 1; cyc(5);
    chk("R4", "disabled edge cpu", cpu_clk_en, 0);
    int_en = 2'b01; cyc(5);
    chk("R4", "level only cpu", cpu_clk_en, 0);
    int1 = 0; cyc(3); int1 = 1; cyc(2);
    chk("R4", "edge in sync cpu", cpu_clk_en, 0);
    cyc(1);
    chk("R4", "edge wake cpu", cpu_clk_en, 1);
    chk("R9", "int1 vector_id", vector_id, 1);
    chk("R8", "resume_pulse", resume_pulse, 1);
    int1 = 0; int_en = 2'b11; cyc(3);

    // priority cases
    go_sleep();
    key_in = 8'hFE; int2 = 1; cyc(3);
    chk("R9", "key+int2 cpu", cpu_clk_en, 1);
    chk("R9", "key beats int2", vector_id, 0);
    key_in = '1; int2 = 0; cyc(3);
    go_sleep();
    int1 = 1; int2 = 1; cyc(3);
    chk("R9", "int1 beats int2", vector_id, 1);
    int1 = 0; int2 = 0; cyc(3);
    go_sleep();
    int2 = 1; cyc(2);
    itmr_tick = 1; itmr_src_ok = 1; itmr_ie = 1; cyc(1);
    chk("R9", "int2+timer cpu", cpu_clk_en, 1);
    chk("R9", "int2 beats timer", vector_id, 2);
    itmr_tick = 0; int2 = 0; cyc(3);

    // deep mode: stop wins, timer ignored, short settle
    stop_req = 1; sleep_req = 1; cyc(1); stop_req = 0; sleep_req = 0;
    chk("R2", "stop osc_en", osc_en, 0);
    chk("R2", "stop cpu_clk_en", cpu_clk_en, 0);
    chk("R2", "stop clk_en_flag", clk_en_flag, 0);
    itmr_tick = 1; cyc(4);
    chk("R5", "timer in stop osc", osc_en, 0);
    chk("R5", "timer in stop cpu", cpu_clk_en, 0);
    itmr_tick = 0;
    settle_sel = 3'd1; key_in = 8'hFE; cyc(3);
    chk("R7", "osc back", osc_en, 1);
    chk("R7", "cpu held", cpu_clk_en, 0);
    settle_sel = 3'd7; key_in = '1; int2 = 1; cyc(7);
    chk("R7", "cpu before span", cpu_clk_en, 0);
    chk("R7", "flag before span", clk_en_flag, 0);
    chk("R10", "int2 during settle no pulse", resume_pulse, 0);
    cyc(1);
    chk("R7", "cpu after 8", cpu_clk_en, 1);
    chk("R7", "flag after 8", clk_en_flag, 1);
    chk("R8", "resume_pulse", resume_pulse, 1);
    chk("R9", "key vector_id", vector_id, 0);
    int2 = 0; cyc(3);

    // deep mode, longest settle, vector
    irq_master_en = 1; stop_req = 1; cyc(1); stop_req = 0;
    int2 = 1; cyc(3);
    chk("R7", "osc back long", osc_en, 1);
    cyc(511);
    chk("R7", "cpu before 512", cpu_clk_en, 0);
    cyc(1);
    chk("R7", "cpu after 512", cpu_clk_en, 1);
    chk("R8", "vector_req", vector_req, 1);
    chk("R9", "int2 vector_id", vector_id, 2);
    int2 = 0; irq_master_en = 0; cyc(3);

    // reset while in standby
    stop_req = 1; cyc(1); stop_req = 0; cyc(2);
    rst = 1; cyc(1); rst = 0;
    chk("R1", "reset in stop osc", osc_en, 1);
    chk("R1", "reset in stop cpu", cpu_clk_en, 1);
    chk("R1", "reset in stop flag", clk_en_flag, 1);
    chk("R1", "reset vector_id", vector_id, 0);
    go_sleep(); cyc(2);
    rst = 1; cyc(1); rst = 0;
    chk("R1", "reset in sleep cpu", cpu_clk_en, 1);
    cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule